// File: doc/BRIEF.md
# Comma Byte-Alignment Tracker

This block follows the byte alignment of a received 10-bit code-group stream. Upstream logic finds commas in the serial data and reports one result per code group: whether the group was a comma, the bit position where the comma was found, and whether the decoder flagged a coding error. The tracker turns these results into a selected alignment offset. It also produces a synchronised status, a data-flow gate and a one-cycle pulse each time the offset moves while the link stays up.

After reset the block searches for alignment. The first comma it sees sets the offset. Four further valid groups then confirm the offset, and the link is declared aligned. While aligned, the block counts commas that appear at a different offset. Four such commas that agree on one new offset, with no comma at another position in between, move the selection to the new offset without stopping the data. A budget of error credit, capped at four, drops alignment when coding errors outnumber clean groups by four. A resync request arrives asynchronously. Once it has passed through a synchronizer, it forces a new search.

Top module: `cma_align_track`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sync_ok`, `data_en` and `realign_pulse` are 0 and `align_pos` is 0.
- R2: While searching, the first valid comma loads its position into `align_pos`. `sync_ok` rises on the edge of the fourth valid group after that comma (the comma itself does not count). It never rises at any other time.
- R3: While confirming, a valid group with a coding error returns the block to searching, provided error checking is enabled. The block then needs a new comma before it can lock.
- R4: While aligned with auto-realign on, the fourth valid comma at one same new offset moves `align_pos` to that offset. `realign_pulse` is high for exactly that one cycle. Non-comma groups or idle cycles between these commas do not break the run.
- R5: A comma at the current offset clears the run of misaligned commas.
- R6: A comma at an offset that is neither the current one nor the run's candidate restarts the run, counting as its first comma.
- R7: With auto-realign off, misaligned commas never change `align_pos`.
- R8: With error checking on, credit starts at 4 on lock. Each clean valid group adds 1, up to a cap of 4, and each errored group removes 1. Alignment is lost on the errored group that takes credit to 0, so four errors in a row from full credit drop `sync_ok`.
- R9: With error checking off, coding errors never affect confirmation or alignment.
- R10: `resync_req_async` goes through a two-flop synchronizer. `sync_ok` falls on the third rising edge after the request is set. While the request is held, the block keeps searching and ignores commas.
- R11: An automatic realignment restores error credit to 4.
- R12: `cfg_auto_realign` and `cfg_err_check` take effect only while the block is not aligned. Changes made while aligned are ignored until alignment is next lost.
- R13: `data_en` equals `grp_valid` while aligned and is 0 otherwise. A realignment does not interrupt it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive code-group clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 1 | A code group is present this cycle |
| grp_is_comma | input | 1 | The group contains a comma |
| grp_comma_pos | input | POS_W | Bit offset of the detected comma |
| grp_code_err | input | 1 | Decoder reported a coding error for the group |
| cfg_auto_realign | input | 1 | Allow automatic move to a new offset |
| cfg_err_check | input | 1 | Enable error-credit loss of alignment |
| resync_req_async | input | 1 | Asynchronous request to drop alignment |
| align_pos | output | POS_W | Selected alignment offset |
| sync_ok | output | 1 | Block is aligned |
| data_en | output | 1 | Gate that passes data only while aligned |
| realign_pulse | output | 1 | One-cycle pulse on an offset change while aligned |

## Verification
On every cycle, the assertions check several properties. Lock only follows confirmation. The realign pulse always moves the offset while data keeps flowing. Both error exhaustion and a synchronized resync request end the aligned state. Latched configuration holds steady while aligned, the misaligned-run counter stays in bounds and credit never passes its cap. The bench's scenarios are needed for the rest. Some cover the exact counts: a run of four, broken runs, and a fourth error versus a third after credit refills. Others cover credit being restored by a realign, the synchronizer latency, and configuration changes being ignored while aligned. The cycle-level reference model compares all outputs on every clock.

// File: rtl/cma_pkg.sv
package cma_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } lock_st_e;
endpackage

// File: rtl/cma_resync.sv
module cma_resync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_async};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/cma_misalign.sv
module cma_misalign #(
  parameter int POS_W   = 4,
  parameter int RUN_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             comma_v,
  input  logic [POS_W-1:0] comma_pos,
  input  logic [POS_W-1:0] cur_pos,
  output logic             hit
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [POS_W-1:0] cand_q, cand_d;

  always_comb begin
    cnt_d  = cnt_q;
    cand_d = cand_q;
    hit    = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (comma_v) begin
      if (comma_pos == cur_pos) begin
        cnt_d = '0;
      end else if (cnt_q == '0 || comma_pos == cand_q) begin
        cand_d = comma_pos;
        if (cnt_q == CW'(RUN_LEN - 1)) begin
          hit   = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end else begin
        cand_d = comma_pos;
        cnt_d  = CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cand_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      cand_q <= cand_d;
    end
  end

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(RUN_LEN));
  assert_clr_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/cma_credit.sv
module cma_credit #(
  parameter int CREDIT_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  logic bad,
  output logic exhaust
);
  localparam int CW = $clog2(CREDIT_MAX + 1);

  logic [CW-1:0] cr_q, cr_d;

  assign exhaust = step & bad & (cr_q == CW'(1));

  always_comb begin
    cr_d = cr_q;
    if (load) begin
      cr_d = CW'(CREDIT_MAX);
    end else if (step) begin
      if (bad) cr_d = (cr_q == '0) ? '0 : cr_q - CW'(1);
      else     cr_d = (cr_q == CW'(CREDIT_MAX)) ? cr_q : cr_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cr_q <= CW'(CREDIT_MAX);
    else        cr_q <= cr_d;
  end

  assert_credit_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cr_q <= CW'(CREDIT_MAX));
  assert_load_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cr_q == CW'(CREDIT_MAX)));
endmodule

// File: rtl/cma_align_track.sv
module cma_align_track
  import cma_pkg::*;
#(
  parameter int POS_W       = 4,
  parameter int RUN_LEN     = 4,
  parameter int CREDIT_MAX  = 4,
  parameter int CONFIRM_LEN = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_valid,
  input  logic             grp_is_comma,
  input  logic [POS_W-1:0] grp_comma_pos,
  input  logic             grp_code_err,
  input  logic             cfg_auto_realign,
  input  logic             cfg_err_check,
  input  logic             resync_req_async,
  output logic [POS_W-1:0] align_pos,
  output logic             sync_ok,
  output logic             data_en,
  output logic             realign_pulse
);
  localparam int GW = $clog2(CONFIRM_LEN + 1);

  lock_st_e         st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [GW-1:0]    good_q, good_d;
  logic             pulse_d;
  logic             cfg_auto_q, cfg_err_q;
  logic             unlocked, eff_auto, eff_err;
  logic             resync_q, locked_grp, lose, hit, realign, confirm_done;
  logic             cr_load, cr_step, ma_clr, ma_comma;

  cma_resync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(resync_req_async), .q(resync_q)
  );

  assign unlocked   = (st_q != ST_LOCKED);
  assign eff_auto   = unlocked ? cfg_auto_realign : cfg_auto_q;
  assign eff_err    = unlocked ? cfg_err_check    : cfg_err_q;
  assign locked_grp = (st_q == ST_LOCKED) & grp_valid & ~resync_q;

  assign confirm_done = (st_q == ST_CONFIRM) & grp_valid & ~resync_q
                      & ~(eff_err & grp_code_err)
                      & (good_q == GW'(CONFIRM_LEN - 1));

  assign cr_step  = locked_grp & eff_err;
  assign ma_clr   = unlocked | resync_q | lose;
  assign ma_comma = locked_grp & grp_is_comma;
  assign realign  = hit & eff_auto;
  assign cr_load  = confirm_done | realign;

  cma_credit #(.CREDIT_MAX(CREDIT_MAX)) u_credit (
    .clk(clk), .rst_n(rst_n), .load(cr_load), .step(cr_step),
    .bad(grp_code_err), .exhaust(lose)
  );

  cma_misalign #(.POS_W(POS_W), .RUN_LEN(RUN_LEN)) u_mis (
    .clk(clk), .rst_n(rst_n), .clr(ma_clr), .comma_v(ma_comma),
    .comma_pos(grp_comma_pos), .cur_pos(pos_q), .hit(hit)
  );

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    good_d  = good_q;
    pulse_d = 1'b0;
    if (resync_q) begin
      st_d   = ST_HUNT;
      good_d = '0;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          if (grp_valid && grp_is_comma) begin
            pos_d  = grp_comma_pos;
            good_d = '0;
            st_d   = ST_CONFIRM;
          end
        end
        ST_CONFIRM: begin
          if (grp_valid) begin
            if (eff_err && grp_code_err) begin
              st_d = ST_HUNT;
            end else if (confirm_done) begin
              st_d   = ST_LOCKED;
              good_d = '0;
            end else begin
              good_d = good_q + GW'(1);
            end
          end
        end
        ST_LOCKED: begin
          if (lose) begin
            st_d = ST_HUNT;
          end else if (realign) begin
            pos_d   = grp_comma_pos;
            pulse_d = 1'b1;
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_HUNT;
      pos_q         <= '0;
      good_q        <= '0;
      realign_pulse <= 1'b0;
    end else begin
      st_q          <= st_d;
      pos_q         <= pos_d;
      good_q        <= good_d;
      realign_pulse <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_auto_q <= 1'b0;
      cfg_err_q  <= 1'b0;
    end else if (unlocked) begin
      cfg_auto_q <= cfg_auto_realign;
      cfg_err_q  <= cfg_err_check;
    end
  end

  assign align_pos = pos_q;
  assign sync_ok   = (st_q == ST_LOCKED);
  assign data_en   = grp_valid & sync_ok;

  assert_lock_from_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> ($past(st_q) == ST_CONFIRM));
  assert_pulse_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    realign_pulse |-> (align_pos != $past(align_pos)));
  assert_flow_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    realign_pulse |-> (sync_ok && $past(sync_ok)));
  assert_err_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lose |=> !sync_ok);
  assert_resync_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resync_q |=> !sync_ok);
  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && $past(sync_ok)) |-> ($stable(cfg_auto_q) && $stable(cfg_err_q)));
  assert_no_err_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_ok && !cfg_err_q && !resync_q) |=> sync_ok);
endmodule

// File: tb/sim_cma_align_track.sv
module sim_cma_align_track;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       gv, gc, ge, ca, ce, fr;
  logic [3:0] gp;
  logic [3:0] align_pos;
  logic       sync_ok, data_en, realign_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  cma_align_track u0 (
    .clk(clk), .rst_n(rst_n), .grp_valid(gv), .grp_is_comma(gc),
    .grp_comma_pos(gp), .grp_code_err(ge), .cfg_auto_realign(ca),
    .cfg_err_check(ce), .resync_req_async(fr), .align_pos(align_pos),
    .sync_ok(sync_ok), .data_en(data_en), .realign_pulse(realign_pulse)
  );

  // behavioural reference model
  int m_st, m_pos, m_good, m_cr, m_cand, m_cnt, m_fr1, m_fr2;
  bit m_cfa, m_cfe, m_pulse;

  always @(posedge clk) begin
    bit ea, ee, lose;
    if (!rst_n) begin
      m_st = 0; m_pos = 0; m_good = 0; m_cr = 4; m_cand = 0; m_cnt = 0;
      m_fr1 = 0; m_fr2 = 0; m_cfa = 0; m_cfe = 0; m_pulse = 0;
    end else begin
      ea = (m_st != 2) ? ca : m_cfa;
      ee = (m_st != 2) ? ce : m_cfe;
      if (m_st != 2) begin m_cfa = ca; m_cfe = ce; end
      m_pulse = 0;
      if (m_fr2 != 0) begin
        m_st = 0; m_good = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        if (gv && gc) begin m_pos = int'(gp); m_st = 1; m_good = 0; end
      end else if (m_st == 1) begin
        if (gv) begin
          if (ee && ge) m_st = 0;
          else begin
            m_good++;
            if (m_good == 4) begin m_st = 2; m_cr = 4; m_cnt = 0; end
          end
        end
      end else if (gv) begin
        lose = ee && ge && (m_cr == 1);
        if (ee) m_cr = ge ? m_cr - 1 : ((m_cr < 4) ? m_cr + 1 : 4);
        if (lose) begin
          m_st = 0; m_cnt = 0;
        end else if (gc) begin
          if (int'(gp) == m_pos) m_cnt = 0;
          else if (m_cnt == 0 || int'(gp) == m_cand) begin m_cand = int'(gp); m_cnt++; end
          else begin m_cand = int'(gp); m_cnt = 1; end
          if (m_cnt == 4) begin
            m_cnt = 0;
            if (ea) begin m_pos = m_cand; m_pulse = 1; m_cr = 4; end
          end
        end
      end
      m_fr2 = m_fr1;
      m_fr1 = int'(fr);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R4 model align_pos", int'(align_pos), m_pos);
      chk("R2 model sync_ok", int'(sync_ok), int'(m_st == 2));
      chk("R4 model realign_pulse", int'(realign_pulse), int'(m_pulse));
      chk("R13 model data_en", int'(data_en), int'(gv && m_st == 2));
    end
  end

  task automatic grp(input bit v, input bit c, input int p, input bit e);
    @(negedge clk);
    gv = v; gc = c; gp = 4'(p); ge = e;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) grp(0, 0, 0, 0);
  endtask

  task automatic lock_at(input int p);
    grp(1, 1, p, 0);
    for (int i = 0; i < 4; i++) grp(1, 0, 0, 0);
  endtask

  task automatic force_hunt();
    @(negedge clk) fr = 1'b1;
    idle(4);
    @(negedge clk) fr = 1'b0;
    idle(3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gv = 0; gc = 0; gp = 0; ge = 0; ca = 1; ce = 1; fr = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset sync_ok", int'(sync_ok), 0);
    chk("R1 reset align_pos", int'(align_pos), 0);
    chk("R1 reset realign_pulse", int'(realign_pulse), 0);
    chk("R1 reset data_en", int'(data_en), 0);
    @(negedge clk) rst_n = 1'b1;

    // R2 acquisition
    grp(1, 0, 0, 0); grp(1, 0, 0, 0);
    chk("R2 no lock without comma", int'(sync_ok), 0);
    grp(1, 1, 3, 0);
    chk("R2 first comma offset", int'(align_pos), 3);
    for (int i = 0; i < 3; i++) grp(1, 0, 0, 0);
    chk("R2 not yet locked after three", int'(sync_ok), 0);
    grp(1, 0, 0, 0);
    chk("R2 locked after four", int'(sync_ok), 1);
    chk("R13 data passes when locked", int'(data_en), 1);

    // R4 realign with gaps
    grp(1, 1, 7, 0); grp(1, 0, 0, 0); grp(1, 1, 7, 0); grp(0, 0, 0, 0); grp(1, 1, 7, 0);
    chk("R4 three commas no move", int'(align_pos), 3);
    grp(1, 1, 7, 0);
    chk("R4 fourth comma moves", int'(align_pos), 7);
    chk("R4 pulse high", int'(realign_pulse), 1);
    chk("R13 flow kept on realign", int'(data_en), 1);
    grp(1, 0, 0, 0);
    chk("R4 pulse one cycle", int'(realign_pulse), 0);

    // R5 aligned comma clears run
    for (int i = 0; i < 3; i++) grp(1, 1, 5, 0);
    grp(1, 1, 7, 0);
    for (int i = 0; i < 3; i++) grp(1, 1, 5, 0);
    chk("R5 run cleared", int'(align_pos), 7);
    grp(1, 1, 5, 0);
    chk("R5 later run completes", int'(align_pos), 5);

    // R6 third offset restarts run
    for (int i = 0; i < 3; i++) grp(1, 1, 2, 0);
    grp(1, 1, 8, 0); grp(1, 1, 8, 0); grp(1, 1, 8, 0);
    chk("R6 restarted run short", int'(align_pos), 5);
    grp(1, 1, 8, 0);
    chk("R6 restarted run completes", int'(align_pos), 8);

    // R8 credit
    for (int i = 0; i < 3; i++) grp(1, 0, 0, 1);
    grp(1, 0, 0, 0); grp(1, 0, 0, 1);
    chk("R8 credit left", int'(sync_ok), 1);
    grp(1, 0, 0, 1);
    chk("R8 credit exhausted", int'(sync_ok), 0);
    lock_at(1);
    for (int i = 0; i < 10; i++) grp(1, 0, 0, 0);
    for (int i = 0; i < 3; i++) grp(1, 0, 0, 1);
    chk("R8 cap three errors", int'(sync_ok), 1);
    grp(1, 0, 0, 1);
    chk("R8 cap fourth error", int'(sync_ok), 0);

    // R11 credit refilled by realign
    lock_at(4);
    grp(1, 1, 6, 1); grp(1, 1, 6, 1); grp(1, 1, 6, 0); grp(1, 1, 6, 1);
    chk("R11 realign at 6", int'(align_pos), 6);
    for (int i = 0; i < 3; i++) grp(1, 0, 0, 1);
    chk("R11 credit full after realign", int'(sync_ok), 1);
    grp(1, 0, 0, 0);

    // R3 error during confirmation
    force_hunt();
    grp(1, 1, 2, 0); grp(1, 0, 0, 0); grp(1, 0, 0, 1);
    for (int i = 0; i < 5; i++) grp(1, 0, 0, 0);
    chk("R3 confirm aborted", int'(sync_ok), 0);

    // R7 / R12
    ca = 1'b0;
    force_hunt();
    lock_at(0);
    ca = 1'b1; ce = 1'b0;
    for (int i = 0; i < 4; i++) grp(1, 1, 9, 0);
    chk("R7 no realign when off", int'(align_pos), 0);
    chk("R12 auto change ignored", int'(realign_pulse), 0);
    for (int i = 0; i < 4; i++) grp(1, 0, 0, 1);
    chk("R12 err check stays latched", int'(sync_ok), 0);

    // R9 error check off
    grp(1, 1, 3, 0);
    for (int i = 0; i < 4; i++) grp(1, 0, 0, 1);
    chk("R9 confirm ignores errors", int'(sync_ok), 1);
    for (int i = 0; i < 8; i++) grp(1, 0, 0, 1);
    chk("R9 lock ignores errors", int'(sync_ok), 1);

    // R10 resync
    ce = 1'b1;
    @(negedge clk) fr = 1'b1;
    @(posedge clk); #2;
    @(posedge clk); #2;
    chk("R10 synchronizer latency", int'(sync_ok), 1);
    @(posedge clk); #2;
    chk("R10 resync drops", int'(sync_ok), 0);
    for (int i = 0; i < 3; i++) grp(1, 1, 5, 0);
    chk("R10 commas ignored while held", int'(align_pos), 3);
    @(negedge clk) fr = 1'b0;
    idle(3);
    lock_at(5);
    chk("R10 relock after release", int'(sync_ok), 1);
    chk("R10 relock offset", int'(align_pos), 5);

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule